// File: doc/BRIEF.md
# Multi-PID Address-Space Checked Translation Buffer

This block is a small fully associative translation buffer for an embedded core. A lookup presents an effective address, an access kind (load, store or instruction fetch), three process-ID registers, the instruction-side and data-side address-space bits and the privilege state. Each stored entry holds a valid flag, a page-size code, a virtual page, a physical page, a tag, an address-space bit and an 8-bit rights byte made of a supervisor nibble and a user nibble.

An entry claims a lookup when its tag fits one of the active IDs, its page covers the address and its address-space bit equals the side selected by the access kind. The lowest-index claiming entry decides the outcome: either the access is granted with a translated address and the effective rights, or a fault code is returned. If no entry claims the lookup, a miss code is returned. The result is registered and shown one clock after the request strobe, together with a one-cycle `done` pulse. Entries are loaded through a simple indexed write port. Raising the fault to the core is left to the surrounding logic.

A build-time switch selects the ID mode. In single-ID mode only the primary ID is used, and the low four bits of the physical page supply translated address bits 35:32. In multi-ID mode two secondary IDs take part as well, and bits 35:32 read zero.

Top module: `pid_tlb`

## Requirements
- R1: While reset is held, and afterwards until the first request, `done`, `hit`, `pa`, `perm` and `result` are all zero. Any lookup that ends in a miss returns `hit`=0, `pa`=0 and `perm`=0.
- R2: `done` is high in exactly the cycle after a cycle in which `req_valid` was sampled high, and low in every other cycle. `hit`, `pa`, `perm` and `result` change only together with `done`.
- R3: An entry whose tag is zero matches any ID. An entry with a nonzero tag matches only when the tag equals one of the active IDs.
- R4: The primary ID is always active. In multi-ID mode (`SINGLE_PID`=0) each secondary ID is also active, but only while its value is nonzero. In single-ID mode both secondary IDs have no effect.
- R5: The page size code s gives a page of 2^(10+2s) bytes. An entry covers an address when the address with its in-page bits cleared equals the stored virtual page. The translated address is the physical page with its in-page bits cleared, ORed with the in-page bits of the address.
- R6: In single-ID mode, `pa[35:32]` is the low four bits of the stored physical page. In multi-ID mode `pa[35:32]` is zero.
- R7: A fetch (`req_kind`=2) compares the entry's space bit with `inst_as`. A load (0) or a store (1) compares it with `data_as`. A mismatch makes that entry count as a miss, and the scan goes on to later entries.
- R8: In user state (`user_mode`=1) the rights come from bits 3:0 of the rights byte, and in supervisor state from bits 7:4. Inside the nibble, bit0 allows read, bit1 allows write and bit2 allows execute. A grant returns `result`=0, `hit`=1 and this nibble on `perm`.
- R9: When the claiming entry lacks the needed right, the result is 3 (execute fault) for a fetch and 2 (protection fault) for a load or store. In both cases `hit`=0, `pa`=0 and `perm` shows the selected nibble. A miss returns 1.
- R10: Entries are examined in ascending index order, and the first claiming entry decides the result. This holds even when that entry faults and a later entry would grant.
- R11: A write with `wr_en`=1 replaces every field of entry `wr_idx`. Writing `wr_valid`=0 removes the entry from all later lookups.
- R12: Reset invalidates every entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Entry write strobe |
| wr_idx | input | IDX_W | Entry index to write |
| wr_valid | input | 1 | Valid flag to store |
| wr_pgsz | input | SZ_W | Page size code to store |
| wr_vpage | input | EA_W | Virtual page to store |
| wr_ppage | input | EA_W | Physical page to store (low 4 bits also carry the high address bits in single-ID mode) |
| wr_tag | input | PID_W | Tag to store (0 = any ID) |
| wr_space | input | 1 | Address-space bit to store |
| wr_rights | input | 8 | Rights byte: [7:4] supervisor, [3:0] user |
| req_valid | input | 1 | Lookup request strobe |
| req_ea | input | EA_W | Effective address |
| req_kind | input | 2 | 0 load, 1 store, 2 fetch (3 acts as load) |
| pid_prim | input | PID_W | Primary ID |
| pid_sec1 | input | PID_W | First secondary ID |
| pid_sec2 | input | PID_W | Second secondary ID |
| inst_as | input | 1 | Instruction-side address space |
| data_as | input | 1 | Data-side address space |
| user_mode | input | 1 | 1 = user state, 0 = supervisor |
| done | output | 1 | One-cycle result strobe |
| hit | output | 1 | Access granted |
| pa | output | EA_W+4 | Translated address |
| perm | output | 4 | Effective rights nibble |
| result | output | 2 | 0 grant, 1 miss, 2 protection fault, 3 execute fault |

## Verification
The bench builds two copies of the block side by side with four entries and a 32-bit address, one with `SINGLE_PID`=0 and one with `SINGLE_PID`=1, and drives both with the same stimulus. The four entries are made to overlap both in address and in tag, so a small table of IDs, addresses at page edges, every access kind, both privilege states and all four address-space pairings covers the whole matrix of priority, space skipping and ID selection. Page codes 0 to 2 put page edges at 1 KB, 4 KB and 16 KB, and a few addresses placed on each side of those edges check the masking.

// File: rtl/pid_tlb_pkg.sv
// Package: shared codes for the multi-ID translation buffer.
// Assumes: access kinds and result codes are two bits wide.
package pid_tlb_pkg;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2
    } acc_e;

    typedef enum logic [1:0] {
        RES_GRANT  = 2'd0,
        RES_MISS   = 2'd1,
        RES_PROT   = 2'd2,
        RES_XFAULT = 2'd3
    } res_e;

    localparam int RIGHT_RD = 0;
    localparam int RIGHT_WR = 1;
    localparam int RIGHT_EX = 2;

    // Picks the rights bit an access kind needs.
    function automatic int need_bit(input logic [1:0] kind);
        if (kind == ACC_FETCH)      return RIGHT_EX;
        else if (kind == ACC_STORE) return RIGHT_WR;
        else                        return RIGHT_RD;
    endfunction

endpackage

// File: rtl/pid_tlb_way.sv
// Module: per-entry compare for one stored translation.
// Decides whether the entry claims a lookup (ID, page and address space all
// fit), whether the selected rights nibble allows the access, and what the
// translated address would be. Purely combinational.
// Assumes: EA_W >= 16, page codes give 2^(MIN_PG+2s) byte pages.
module pid_tlb_way
    import pid_tlb_pkg::*;
#(
    parameter int EA_W       = 32,
    parameter int PID_W      = 8,
    parameter int SZ_W       = 3,
    parameter int MIN_PG     = 10,
    parameter bit SINGLE_PID = 1'b0,
    localparam int PA_W      = EA_W + 4
) (
    input  logic             e_valid,
    input  logic [SZ_W-1:0]  e_pgsz,
    input  logic [EA_W-1:0]  e_vpage,
    input  logic [EA_W-1:0]  e_ppage,
    input  logic [PID_W-1:0] e_tag,
    input  logic             e_space,
    input  logic [7:0]       e_rights,
    input  logic [EA_W-1:0]  q_ea,
    input  logic [1:0]       q_kind,
    input  logic [PID_W-1:0] q_pid0,
    input  logic [PID_W-1:0] q_pid1,
    input  logic [PID_W-1:0] q_pid2,
    input  logic             q_ispace,
    input  logic             q_dspace,
    input  logic             q_user,
    output logic             claim,
    output logic             allow,
    output logic [3:0]       nib,
    output logic [PA_W-1:0]  pa
);

    logic            tag_ok;
    logic            addr_ok;
    logic            space_ok;
    logic [EA_W-1:0] low_mask;
    logic [EA_W-1:0] base;
    int              pg_bits;

    // ID selection: primary always; secondaries only in multi-ID builds and when nonzero.
    generate
        if (SINGLE_PID) begin : g_single
            assign tag_ok = (e_tag == '0) || (e_tag == q_pid0);
        end else begin : g_multi
            assign tag_ok = (e_tag == '0) || (e_tag == q_pid0)
                         || ((q_pid1 != '0) && (e_tag == q_pid1))
                         || ((q_pid2 != '0) && (e_tag == q_pid2));
        end
    endgenerate

    // Page masking, space check, rights selection and address forming.
    always_comb begin
        pg_bits  = MIN_PG + 2 * int'(e_pgsz);
        low_mask = (pg_bits >= EA_W) ? '1 : ((EA_W'(1) << pg_bits) - EA_W'(1));
        addr_ok  = ((q_ea & ~low_mask) == e_vpage);
        space_ok = (((q_kind == ACC_FETCH) ? q_ispace : q_dspace) == e_space);
        claim    = e_valid && tag_ok && addr_ok && space_ok;
        nib      = q_user ? e_rights[3:0] : e_rights[7:4];
        allow    = nib[need_bit(q_kind)];
        base     = (e_ppage & ~low_mask) | (q_ea & low_mask);
        pa       = SINGLE_PID ? {e_ppage[3:0], base} : {4'b0000, base};
    end

endmodule

// File: rtl/pid_tlb_pick.sv
// Module: lowest-index priority select over the per-entry compares.
// The first claiming entry wins, whether it grants or faults.
// Assumes: N >= 1.
module pid_tlb_pick #(
    parameter int N    = 8,
    parameter int PA_W = 36
) (
    input  logic [N-1:0]           claim,
    input  logic [N-1:0]           allow,
    input  logic [N-1:0][3:0]      nib,
    input  logic [N-1:0][PA_W-1:0] pa,
    output logic                   found,
    output logic                   sel_allow,
    output logic [3:0]             sel_nib,
    output logic [PA_W-1:0]        sel_pa
);

    // Scan from the top down so the lowest claiming index is the one left standing.
    always_comb begin
        found     = 1'b0;
        sel_allow = 1'b0;
        sel_nib   = '0;
        sel_pa    = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (claim[i]) begin
                found     = 1'b1;
                sel_allow = allow[i];
                sel_nib   = nib[i];
                sel_pa    = pa[i];
            end
        end
    end

endmodule

// File: rtl/pid_tlb.sv
// Module: multi-ID, address-space checked translation buffer (top).
// Holds N_ENT entries written through an indexed port, compares all of them
// against each request in parallel, and registers the outcome of the lowest
// claiming entry one clock after req_valid.
// Assumes: synchronous active-low reset; writes and lookups in the same
// cycle see the contents before the write.
module pid_tlb
    import pid_tlb_pkg::*;
#(
    parameter int N_ENT      = 8,
    parameter int EA_W       = 32,
    parameter int PID_W      = 8,
    parameter int SZ_W       = 3,
    parameter int MIN_PG     = 10,
    parameter bit SINGLE_PID = 1'b0,
    localparam int IDX_W     = (N_ENT > 1) ? $clog2(N_ENT) : 1,
    localparam int PA_W      = EA_W + 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_valid,
    input  logic [SZ_W-1:0]  wr_pgsz,
    input  logic [EA_W-1:0]  wr_vpage,
    input  logic [EA_W-1:0]  wr_ppage,
    input  logic [PID_W-1:0] wr_tag,
    input  logic             wr_space,
    input  logic [7:0]       wr_rights,
    input  logic             req_valid,
    input  logic [EA_W-1:0]  req_ea,
    input  logic [1:0]       req_kind,
    input  logic [PID_W-1:0] pid_prim,
    input  logic [PID_W-1:0] pid_sec1,
    input  logic [PID_W-1:0] pid_sec2,
    input  logic             inst_as,
    input  logic             data_as,
    input  logic             user_mode,
    output logic             done,
    output logic             hit,
    output logic [PA_W-1:0]  pa,
    output logic [3:0]       perm,
    output logic [1:0]       result
);

    logic [N_ENT-1:0]            ent_valid;
    logic [N_ENT-1:0][SZ_W-1:0]  ent_pgsz;
    logic [N_ENT-1:0][EA_W-1:0]  ent_vpage;
    logic [N_ENT-1:0][EA_W-1:0]  ent_ppage;
    logic [N_ENT-1:0][PID_W-1:0] ent_tag;
    logic [N_ENT-1:0]            ent_space;
    logic [N_ENT-1:0][7:0]       ent_rights;

    logic [N_ENT-1:0]            w_claim;
    logic [N_ENT-1:0]            w_allow;
    logic [N_ENT-1:0][3:0]       w_nib;
    logic [N_ENT-1:0][PA_W-1:0]  w_pa;

    logic                        s_found;
    logic                        s_allow;
    logic [3:0]                  s_nib;
    logic [PA_W-1:0]             s_pa;
    res_e                        s_res;

    // Valid flags: cleared by reset, set or cleared by the write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_valid <= '0;
        end else if (wr_en) begin
            ent_valid[wr_idx] <= wr_valid;
        end
    end

    // Entry payload: written by the write port, never read while invalid.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            ent_pgsz[wr_idx]   <= wr_pgsz;
            ent_vpage[wr_idx]  <= wr_vpage;
            ent_ppage[wr_idx]  <= wr_ppage;
            ent_tag[wr_idx]    <= wr_tag;
            ent_space[wr_idx]  <= wr_space;
            ent_rights[wr_idx] <= wr_rights;
        end
    end

    generate
        for (genvar g = 0; g < N_ENT; g++) begin : g_way
            pid_tlb_way #(
                .EA_W       (EA_W),
                .PID_W      (PID_W),
                .SZ_W       (SZ_W),
                .MIN_PG     (MIN_PG),
                .SINGLE_PID (SINGLE_PID)
            ) u_way (
                .e_valid  (ent_valid[g]),
                .e_pgsz   (ent_pgsz[g]),
                .e_vpage  (ent_vpage[g]),
                .e_ppage  (ent_ppage[g]),
                .e_tag    (ent_tag[g]),
                .e_space  (ent_space[g]),
                .e_rights (ent_rights[g]),
                .q_ea     (req_ea),
                .q_kind   (req_kind),
                .q_pid0   (pid_prim),
                .q_pid1   (pid_sec1),
                .q_pid2   (pid_sec2),
                .q_ispace (inst_as),
                .q_dspace (data_as),
                .q_user   (user_mode),
                .claim    (w_claim[g]),
                .allow    (w_allow[g]),
                .nib      (w_nib[g]),
                .pa       (w_pa[g])
            );
        end
    endgenerate

    pid_tlb_pick #(
        .N    (N_ENT),
        .PA_W (PA_W)
    ) u_pick (
        .claim     (w_claim),
        .allow     (w_allow),
        .nib       (w_nib),
        .pa        (w_pa),
        .found     (s_found),
        .sel_allow (s_allow),
        .sel_nib   (s_nib),
        .sel_pa    (s_pa)
    );

    // Result code from the winning entry and the access kind.
    always_comb begin
        if (!s_found)                  s_res = RES_MISS;
        else if (s_allow)              s_res = RES_GRANT;
        else if (req_kind == ACC_FETCH) s_res = RES_XFAULT;
        else                           s_res = RES_PROT;
    end

    // Output register: captures the outcome one clock after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done   <= 1'b0;
            hit    <= 1'b0;
            pa     <= '0;
            perm   <= '0;
            result <= '0;
        end else begin
            done <= req_valid;
            if (req_valid) begin
                hit    <= (s_res == RES_GRANT);
                pa     <= (s_res == RES_GRANT) ? s_pa : '0;
                perm   <= s_found ? s_nib : 4'b0000;
                result <= s_res;
            end
        end
    end

endmodule

// File: rtl/pid_tlb_chk.sv
// Module: property checker for pid_tlb, attached with bind below.
// Assumes: it sees the top-level ports only.
module pid_tlb_chk #(
    parameter int PA_W       = 36,
    parameter bit SINGLE_PID = 1'b0
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic [1:0]      req_kind,
    input logic            done,
    input logic            hit,
    input logic [PA_W-1:0] pa,
    input logic [3:0]      perm,
    input logic [1:0]      result
);

    a_r2_done_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> done);

    a_r2_done_only_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !done);

    a_r2_outputs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ($stable(hit) && $stable(pa) && $stable(perm) && $stable(result)));

    a_r1_miss_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (done && result == 2'd1) |-> (!hit && pa == '0 && perm == 4'd0));

    a_r9_exec_fault_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (done && result == 2'd3) |-> ($past(req_kind) == 2'd2 && !hit && pa == '0));

    a_r9_prot_fault_data: assert property (@(posedge clk) disable iff (!rst_n)
        (done && result == 2'd2) |-> ($past(req_kind) != 2'd2 && !hit && pa == '0));

    a_r8_grant_has_right: assert property (@(posedge clk) disable iff (!rst_n)
        (done && hit) |-> (result == 2'd0 &&
            (($past(req_kind) == 2'd2) ? perm[2] :
             ($past(req_kind) == 2'd1) ? perm[1] : perm[0])));

    generate
        if (!SINGLE_PID) begin : g_multi_chk
            a_r6_no_high_bits: assert property (@(posedge clk) disable iff (!rst_n)
                done |-> (pa[PA_W-1:PA_W-4] == 4'd0));
        end
    endgenerate

endmodule

bind pid_tlb pid_tlb_chk #(
    .PA_W       (PA_W),
    .SINGLE_PID (SINGLE_PID)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_kind  (req_kind),
    .done      (done),
    .hit       (hit),
    .pa        (pa),
    .perm      (perm),
    .result    (result)
);

// File: tb/test_pid_tlb.sv
// Bench: two builds (multi-ID and single-ID) driven with shared stimulus,
// compared against a reference model written from the requirements.
module test_pid_tlb;

    localparam int N  = 4;
    localparam int EW = 32;
    localparam int PW = 8;
    localparam int SW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_idx = '0;
    logic          wr_valid = 1'b0;
    logic [SW-1:0] wr_pgsz = '0;
    logic [EW-1:0] wr_vpage = '0;
    logic [EW-1:0] wr_ppage = '0;
    logic [PW-1:0] wr_tag = '0;
    logic          wr_space = 1'b0;
    logic [7:0]    wr_rights = '0;
    logic          req_valid = 1'b0;
    logic [EW-1:0] req_ea = '0;
    logic [1:0]    req_kind = '0;
    logic [PW-1:0] pid_prim = '0;
    logic [PW-1:0] pid_sec1 = '0;
    logic [PW-1:0] pid_sec2 = '0;
    logic          inst_as = 1'b0;
    logic          data_as = 1'b0;
    logic          user_mode = 1'b0;

    logic          m_done, s_done, m_hit, s_hit;
    logic [35:0]   m_pa, s_pa;
    logic [3:0]    m_perm, s_perm;
    logic [1:0]    m_res, s_res;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // Mirror of the written entries for the reference model.
    logic          r_valid  [N];
    logic [SW-1:0] r_pgsz   [N];
    logic [EW-1:0] r_vpage  [N];
    logic [EW-1:0] r_ppage  [N];
    logic [PW-1:0] r_tag    [N];
    logic          r_space  [N];
    logic [7:0]    r_rights [N];

    always #2ns clk = ~clk;

    pid_tlb #(.N_ENT(N), .EA_W(EW), .PID_W(PW), .SZ_W(SW), .MIN_PG(10), .SINGLE_PID(1'b0)) i_pid_tlb (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_valid(wr_valid),
        .wr_pgsz(wr_pgsz), .wr_vpage(wr_vpage), .wr_ppage(wr_ppage), .wr_tag(wr_tag),
        .wr_space(wr_space), .wr_rights(wr_rights), .req_valid(req_valid), .req_ea(req_ea),
        .req_kind(req_kind), .pid_prim(pid_prim), .pid_sec1(pid_sec1), .pid_sec2(pid_sec2),
        .inst_as(inst_as), .data_as(data_as), .user_mode(user_mode),
        .done(m_done), .hit(m_hit), .pa(m_pa), .perm(m_perm), .result(m_res));

    pid_tlb #(.N_ENT(N), .EA_W(EW), .PID_W(PW), .SZ_W(SW), .MIN_PG(10), .SINGLE_PID(1'b1)) i_pid_tlb_single (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_valid(wr_valid),
        .wr_pgsz(wr_pgsz), .wr_vpage(wr_vpage), .wr_ppage(wr_ppage), .wr_tag(wr_tag),
        .wr_space(wr_space), .wr_rights(wr_rights), .req_valid(req_valid), .req_ea(req_ea),
        .req_kind(req_kind), .pid_prim(pid_prim), .pid_sec1(pid_sec1), .pid_sec2(pid_sec2),
        .inst_as(inst_as), .data_as(data_as), .user_mode(user_mode),
        .done(s_done), .hit(s_hit), .pa(s_pa), .perm(s_perm), .result(s_res));

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    // Reference model written from R3..R10.
    function automatic void model(input bit single, output logic [1:0] res,
                                  output logic [3:0] nib, output logic [35:0] adr);
        res = 2'd1; nib = 4'd0; adr = '0;
        for (int i = 0; i < N; i++) begin
            int          pb;
            logic [31:0] lm;
            bit          idok;
            logic        sp;
            logic [3:0]  nb;
            int          nbit;
            pb = 10 + 2 * int'(r_pgsz[i]);
            lm = (32'd1 << pb) - 32'd1;
            idok = (r_tag[i] == 0) || (r_tag[i] == pid_prim);
            if (!single) idok = idok || (pid_sec1 != 0 && r_tag[i] == pid_sec1)
                                     || (pid_sec2 != 0 && r_tag[i] == pid_sec2);
            sp = (req_kind == 2'd2) ? inst_as : data_as;
            if (r_valid[i] && idok && ((req_ea & ~lm) == r_vpage[i]) && sp == r_space[i]) begin
                nb = user_mode ? r_rights[i][3:0] : r_rights[i][7:4];
                nbit = (req_kind == 2'd2) ? 2 : (req_kind == 2'd1) ? 1 : 0;
                nib = nb;
                if (nb[nbit]) begin
                    res = 2'd0;
                    adr[31:0] = (r_ppage[i] & ~lm) | (req_ea & lm);
                    adr[35:32] = single ? r_ppage[i][3:0] : 4'd0;
                end else begin
                    res = (req_kind == 2'd2) ? 2'd3 : 2'd2;
                end
                return;
            end
        end
    endfunction

    task automatic put(input int idx, input logic v, input logic [2:0] sz, input logic [31:0] vp,
                       input logic [31:0] pp, input logic [7:0] tg, input logic spc, input logic [7:0] rt);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 2'(idx); wr_valid = v; wr_pgsz = sz; wr_vpage = vp;
        wr_ppage = pp; wr_tag = tg; wr_space = spc; wr_rights = rt;
        r_valid[idx] = v; r_pgsz[idx] = sz; r_vpage[idx] = vp; r_ppage[idx] = pp;
        r_tag[idx] = tg; r_space[idx] = spc; r_rights[idx] = rt;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic ask(input logic [31:0] ea, input logic [1:0] kind, input logic [7:0] p0,
                       input logic [7:0] p1, input logic [7:0] p2, input logic ias,
                       input logic das, input logic usr);
        @(negedge clk);
        req_ea = ea; req_kind = kind; pid_prim = p0; pid_sec1 = p1; pid_sec2 = p2;
        inst_as = ias; data_as = das; user_mode = usr; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Compare both builds against the model (R10 result, R5 address, R8 rights).
    task automatic cmp_model(input string tag);
        logic [1:0]  er;
        logic [3:0]  en;
        logic [35:0] ea_;
        model(1'b0, er, en, ea_);
        check({tag, " R10 multi result"}, 64'(m_res), 64'(er));
        check({tag, " R5 multi pa"}, 64'(m_pa), 64'(ea_));
        check({tag, " R8 multi perm"}, 64'(m_perm), 64'(en));
        check({tag, " R8 multi hit"}, 64'(m_hit), 64'(er == 2'd0));
        model(1'b1, er, en, ea_);
        check({tag, " R10 single result"}, 64'(s_res), 64'(er));
        check({tag, " R6 single pa"}, 64'(s_pa), 64'(ea_));
        check({tag, " R8 single perm"}, 64'(s_perm), 64'(en));
    endtask

    function automatic logic [23:0] pid_set(input int k);
        case (k)
            0: return {8'd3, 8'd0, 8'd0};
            1: return {8'd9, 8'd0, 8'd0};
            2: return {8'd1, 8'd3, 8'd0};
            3: return {8'd1, 8'd0, 8'd9};
            4: return {8'd0, 8'd0, 8'd0};
            default: return {8'd2, 8'd9, 8'd3};
        endcase
    endfunction

    function automatic logic [31:0] ea_set(input int k);
        case (k)
            0: return 32'h0000_0400;
            1: return 32'h0000_07FC;
            2: return 32'h0000_0800;
            3: return 32'h0001_0000;
            4: return 32'h0001_3FFF;
            5: return 32'h0001_4000;
            default: return 32'h0001_0FF0;
        endcase
    endfunction

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            r_valid[i] = 1'b0; r_pgsz[i] = '0; r_vpage[i] = '0; r_ppage[i] = '0;
            r_tag[i] = '0; r_space[i] = 1'b0; r_rights[i] = '0;
        end
        repeat (3) @(negedge clk);
        // R1: reset state of the outputs.
        check("R1 done in reset", 64'(m_done), 64'd0);
        check("R1 result in reset", 64'(m_res), 64'd0);
        check("R1 pa in reset", 64'(s_pa), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 hit after reset", 64'(m_hit), 64'd0);
        check("R1 done idle", 64'(s_done), 64'd0);

        // R12: all entries invalid after reset (global-tag lookup still misses).
        ask(32'h0000_0400, 2'd0, 8'd0, 8'd0, 8'd0, 1'b0, 1'b0, 1'b0);
        check("R12 miss after reset", 64'(m_res), 64'd1);
        check("R12 miss after reset single", 64'(s_res), 64'd1);
        check("R2 done pulse", 64'(m_done), 64'd1);
        @(negedge clk);
        check("R2 done drops", 64'(m_done), 64'd0);
        check("R2 result held", 64'(m_res), 64'd1);

        // Directed entry: 4 KB page, tag 7, space 0, supervisor rw, user rwx.
        put(0, 1'b1, 3'd1, 32'h0000_3000, 32'h1234_5005, 8'd7, 1'b0, 8'h37);
        ask(32'h0000_3ABC, 2'd0, 8'd7, 8'd0, 8'd0, 1'b0, 1'b0, 1'b1);
        check("R5 grant result", 64'(m_res), 64'd0);
        check("R5 translated", 64'(m_pa), 64'h0_1234_5ABC);
        check("R6 single high bits", 64'(s_pa), 64'h5_1234_5ABC);
        check("R8 user nibble", 64'(m_perm), 64'h7);
        check("R8 hit", 64'(m_hit), 64'd1);
        ask(32'h0000_3ABC, 2'd0, 8'd2, 8'd0, 8'd0, 1'b0, 1'b0, 1'b1);
        check("R3 wrong id misses", 64'(m_res), 64'd1);
        check("R1 miss clears pa", 64'(m_pa), 64'd0);
        check("R1 miss clears perm", 64'(m_perm), 64'd0);
        ask(32'h0000_3ABC, 2'd0, 8'd2, 8'd7, 8'd0, 1'b0, 1'b0, 1'b1);
        check("R4 first secondary multi", 64'(m_res), 64'd0);
        check("R4 secondary ignored single", 64'(s_res), 64'd1);
        ask(32'h0000_3ABC, 2'd0, 8'd2, 8'd0, 8'd7, 1'b0, 1'b0, 1'b1);
        check("R4 second secondary multi", 64'(m_res), 64'd0);
        check("R4 second secondary single", 64'(s_res), 64'd1);
        ask(32'h0000_3ABC, 2'd2, 8'd7, 8'd0, 8'd0, 1'b0, 1'b0, 1'b0);
        check("R9 execute fault", 64'(m_res), 64'd3);
        check("R9 fault perm shown", 64'(m_perm), 64'h3);
        check("R9 fault no hit", 64'(m_hit), 64'd0);
        ask(32'h0000_3ABC, 2'd1, 8'd7, 8'd0, 8'd0, 1'b0, 1'b0, 1'b0);
        check("R8 supervisor store", 64'(m_res), 64'd0);
        put(1, 1'b1, 3'd0, 32'h0000_0400, 32'h0000_0800, 8'd0, 1'b0, 8'h15);
        ask(32'h0000_0404, 2'd1, 8'd5, 8'd0, 8'd0, 1'b0, 1'b0, 1'b1);
        check("R9 protection fault", 64'(m_res), 64'd2);
        check("R3 zero tag any id", 64'(s_perm), 64'h5);
        ask(32'h0000_3ABC, 2'd0, 8'd7, 8'd0, 8'd0, 1'b0, 1'b1, 1'b1);
        check("R7 data space mismatch", 64'(m_res), 64'd1);
        ask(32'h0000_3ABC, 2'd2, 8'd7, 8'd0, 8'd0, 1'b0, 1'b1, 1'b1);
        check("R7 fetch uses inst space", 64'(m_res), 64'd0);
        ask(32'h0000_4000, 2'd0, 8'd7, 8'd0, 8'd0, 1'b0, 1'b0, 1'b1);
        check("R5 past page end", 64'(m_res), 64'd1);
        ask(32'h0000_2FFF, 2'd0, 8'd7, 8'd0, 8'd0, 1'b0, 1'b0, 1'b1);
        check("R5 before page start", 64'(m_res), 64'd1);
        put(0, 1'b0, 3'd1, 32'h0000_3000, 32'h1234_5005, 8'd7, 1'b0, 8'h37);
        ask(32'h0000_3ABC, 2'd0, 8'd7, 8'd0, 8'd0, 1'b0, 1'b0, 1'b1);
        check("R11 invalidated entry", 64'(m_res), 64'd1);

        // Overlapping entries for the sweep (R7 skip, R10 priority).
        put(0, 1'b1, 3'd0, 32'h0000_0400, 32'h0008_0402, 8'd0, 1'b1, 8'h15);
        put(1, 1'b1, 3'd2, 32'h0001_0000, 32'h0F00_0009, 8'd3, 1'b0, 8'h73);
        put(2, 1'b1, 3'd0, 32'h0000_0400, 32'h0000_8001, 8'd9, 1'b0, 8'h77);
        put(3, 1'b1, 3'd1, 32'h0001_0000, 32'h2000_000C, 8'd3, 1'b0, 8'h77);
        for (int e = 0; e < 7; e++) begin
            for (int p = 0; p < 6; p++) begin
                for (int k = 0; k < 3; k++) begin
                    for (int u = 0; u < 2; u++) begin
                        for (int a = 0; a < 4; a++) begin
                            logic [23:0] ps;
                            ps = pid_set(p);
                            ask(ea_set(e), 2'(k), ps[23:16], ps[15:8], ps[7:0], a[1], a[0], u[0]);
                            cmp_model("sweep R7 R3 R4");
                        end
                    end
                end
            end
        end
        // R10: a faulting lower entry wins over a granting later one.
        ask(32'h0001_0000, 2'd2, 8'd3, 8'd0, 8'd0, 1'b0, 1'b0, 1'b1);
        check("R10 lower entry faults first", 64'(m_res), 64'd3);
        // R11: with entry 1 removed, entry 3 decides.
        put(1, 1'b0, 3'd2, 32'h0001_0000, 32'h0F00_0009, 8'd3, 1'b0, 8'h73);
        ask(32'h0001_0000, 2'd2, 8'd3, 8'd0, 8'd0, 1'b0, 1'b0, 1'b1);
        check("R11 next entry after removal", 64'(m_res), 64'd0);
        check("R11 next entry pa", 64'(m_pa), 64'h0_2000_0000);
        check("R6 next entry single pa", 64'(s_pa), 64'hC_2000_0000);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule